// File: doc/BRIEF.md
# Register Write Spacing Throttle

This block sits on the register-write path between a host and a peripheral whose control registers cross into a slow clock domain, where two writes that land too close together can lose one of them. Every write the host offers is held off, by keeping the write-ready low, until a minimum number of microsecond ticks has elapsed since the last write that went out. The single address of the peripheral's data buffer is exempt from the wait. Writes to it go out at once, but they still restart the spacing interval.

Time is kept by a free-running tick counter that advances on a one-cycle microsecond pulse. A write that goes out records the current count as its timestamp, and the gap is measured as an unsigned, wrapping difference between the live count and that timestamp. The default gap is derived from the slowest peripheral clock: two of its periods in microseconds, plus one as a rounding margin. For a 400 kHz clock this gives 6 µs. Reads are forwarded straight to the peripheral and are never held.

Top module: `wr_gap_throttle`

## Requirements
- R1: After reset the tick count and the write timestamp are both zero and `per_wr_en` is low, so the first write to a non-exempt address is held until GAP_US ticks have been counted since reset.
- R2: While the wrapping difference (tick count − timestamp) is below GAP_US, a write to any address other than BUF_ADDR sees `wr_ready` low.
- R3: A write whose full byte address equals BUF_ADDR (default 0x20) sees `wr_ready` high in the same cycle, regardless of the elapsed time.
- R4: Every accepted write, including one to BUF_ADDR, loads the timestamp with the tick count of its acceptance cycle. A non-exempt write that follows an exempt one therefore waits a full gap.
- R5: A write accepted on a clock edge (`wr_valid` and `wr_ready` high) appears on `per_wr_en`/`per_wr_addr`/`per_wr_data` for exactly the following cycle, with the same address and data. `per_wr_en` is low in every other cycle.
- R6: Reads are combinational pass-through: `per_rd_en` and `per_rd_addr` follow `rd_en` and `rd_addr`, and `rd_data` follows `per_rd_data`, even while a write is stalled.
- R7: The elapsed time is the CNT_W-bit unsigned difference, so spacing stays correct when the tick count wraps past zero.
- R8: `wr_ready` rises for a non-exempt write in exactly the cycle where the elapsed difference equals GAP_US.
- R9: GAP_US defaults to 2·10⁶/SLOW_HZ + 1, which is 6 for SLOW_HZ = 400000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_addr | input | AW | Host write byte address |
| wr_data | input | DW | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read byte address |
| rd_data | output | DW | Read data returned to host |
| per_wr_en | output | 1 | Registered write strobe to peripheral |
| per_wr_addr | output | AW | Registered write address to peripheral |
| per_wr_data | output | DW | Registered write data to peripheral |
| per_rd_en | output | 1 | Read strobe to peripheral |
| per_rd_addr | output | AW | Read address to peripheral |
| per_rd_data | input | DW | Read data from peripheral |

## Verification
The bench builds the block with CNT_W = 8 and SLOW_HZ = 500000. The narrow counter makes the tick count wrap every 256 µs, so stalls that straddle zero are exercised many times in a short run. The changed SLOW_HZ gives a derived gap of 5 and shows that the formula, not a fixed constant, sets the interval. With a tick every third clock, each gap spans about fifteen cycles, and the exact cycle where ready rises can be checked against the bench's own tick model.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

  // Two periods of the slowest peripheral clock in whole microseconds,
  // plus one microsecond of rounding margin.
  function automatic int unsigned two_tick_us(input int unsigned slow_hz);
    return (2 * 1000000) / slow_hz + 1;
  endfunction

  typedef enum logic [0:0] {
    GATE_HOLD = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

endpackage

// File: rtl/us_stamp_counter.sv
module us_stamp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  output logic [CNT_W-1:0] now_us
);

  always_ff @(posedge clk) begin
    if (rst) begin
      now_us <= '0;
    end else if (us_tick) begin
      now_us <= now_us + 1'b1;
    end
  end

endmodule

// File: rtl/gap_gate.sv
module gap_gate #(
  parameter int          CNT_W  = 32,
  parameter int unsigned GAP_US = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] now_us,
  input  logic             fire,
  input  logic             exempt,
  output logic             ready,
  output logic [CNT_W-1:0] last_us
);
  import wgt_pkg::*;

  localparam logic [CNT_W-1:0] GAP_C = CNT_W'(GAP_US);

  logic [CNT_W-1:0] elapsed;
  gate_state_e      state;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_us <= '0;
    end else if (fire) begin
      last_us <= now_us;
    end
  end

  assign elapsed = now_us - last_us;

  generate
    if (GAP_US == 0) begin : g_nogap
      assign state = GATE_OPEN;
    end else begin : g_gap
      assign state = (elapsed >= GAP_C) ? GATE_OPEN : GATE_HOLD;
    end
  endgenerate

  assign ready = exempt || (state == GATE_OPEN);

endmodule

// File: rtl/wr_issue_reg.sv
module wr_issue_reg #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_en,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en <= 1'b0;
    end else begin
      out_en <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_data <= '0;
    end else if (fire) begin
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/wr_gap_throttle.sv
module wr_gap_throttle #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          CNT_W    = 32,
  parameter int unsigned BUF_ADDR = 32'h20,
  parameter int unsigned SLOW_HZ  = 400000,
  parameter int unsigned GAP_US   = wgt_pkg::two_tick_us(SLOW_HZ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          per_wr_en,
  output logic [AW-1:0] per_wr_addr,
  output logic [DW-1:0] per_wr_data,
  output logic          per_rd_en,
  output logic [AW-1:0] per_rd_addr,
  input  logic [DW-1:0] per_rd_data
);

  localparam logic [AW-1:0] BUF_A = AW'(BUF_ADDR);

  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] last_q;
  logic             is_buf;
  logic             fire;

  assign is_buf = (wr_addr == BUF_A);
  assign fire   = wr_valid && wr_ready;

  us_stamp_counter #(.CNT_W(CNT_W)) u_clock (
    .clk     (clk),
    .rst     (rst),
    .us_tick (us_tick),
    .now_us  (now_q)
  );

  gap_gate #(.CNT_W(CNT_W), .GAP_US(GAP_US)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .now_us  (now_q),
    .fire    (fire),
    .exempt  (is_buf),
    .ready   (wr_ready),
    .last_us (last_q)
  );

  wr_issue_reg #(.AW(AW), .DW(DW)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .in_addr  (wr_addr),
    .in_data  (wr_data),
    .out_en   (per_wr_en),
    .out_addr (per_wr_addr),
    .out_data (per_wr_data)
  );

  // Reads bypass the gate entirely (R6).
  assign per_rd_en   = rd_en;
  assign per_rd_addr = rd_addr;
  assign rd_data     = per_rd_data;

endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          CNT_W    = 32,
  parameter int unsigned BUF_ADDR = 32'h20,
  parameter int unsigned GAP_US   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             per_wr_en,
  input logic [AW-1:0]    per_wr_addr,
  input logic [DW-1:0]    per_wr_data,
  input logic [CNT_W-1:0] now_us,
  input logic [CNT_W-1:0] last_us
);

  localparam logic [AW-1:0]    BUF_A = AW'(BUF_ADDR);
  localparam logic [CNT_W-1:0] GAP_C = CNT_W'(GAP_US);

  logic [CNT_W-1:0] gap_seen;
  assign gap_seen = now_us - last_us;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (last_us == '0 && now_us == '0 && !per_wr_en));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr != BUF_A && gap_seen < GAP_C) |-> !wr_ready);

  p_exempt_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == BUF_A) |-> wr_ready);

  p_stamp_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (last_us == $past(now_us)));

  p_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (per_wr_en && per_wr_addr == $past(wr_addr)
                                && per_wr_data == $past(wr_data)));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> !per_wr_en);

  p_open_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && gap_seen >= GAP_C) |-> wr_ready);

endmodule

bind wr_gap_throttle wgt_checker #(
  .AW(AW), .DW(DW), .CNT_W(CNT_W), .BUF_ADDR(BUF_ADDR), .GAP_US(GAP_US)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .per_wr_en   (per_wr_en),
  .per_wr_addr (per_wr_addr),
  .per_wr_data (per_wr_data),
  .now_us      (now_q),
  .last_us     (last_q)
);

// File: tb/sim_wr_gap_throttle.sv
`timescale 1ns/1ps
module sim_wr_gap_throttle;

  localparam int AW       = 8;
  localparam int DW       = 32;
  localparam int CNT_W    = 8;
  localparam int SLOW_HZ  = 500000;
  localparam int BUF      = 32'h20;
  localparam int GAP      = 5;      // R9: 2e6/500000 + 1
  localparam int TICK_DIV = 3;
  localparam int CYCLES   = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          us_tick = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          per_wr_en;
  logic [AW-1:0] per_wr_addr;
  logic [DW-1:0] per_wr_data;
  logic          per_rd_en;
  logic [AW-1:0] per_rd_addr;
  logic [DW-1:0] per_rd_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cyc    = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  wr_gap_throttle #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .BUF_ADDR(BUF), .SLOW_HZ(SLOW_HZ)
  ) u0 (
    .clk(clk), .rst(rst), .us_tick(us_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
    .per_rd_en(per_rd_en), .per_rd_addr(per_rd_addr), .per_rd_data(per_rd_data)
  );

  // Bench reference model, updated like registers at the clock edge.
  logic [CNT_W-1:0] m_now, m_last;
  logic             m_en;
  logic [AW-1:0]    m_addr;
  logic [DW-1:0]    m_data;
  bit               any_write, last_buf;

  function automatic bit exp_ready(input logic [AW-1:0] a,
                                   input logic [CNT_W-1:0] now_v,
                                   input logic [CNT_W-1:0] last_v);
    logic [CNT_W-1:0] el;
    el = now_v - last_v;
    return (a == AW'(BUF)) || (el >= CNT_W'(GAP));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_now <= '0; m_last <= '0; m_en <= 1'b0; m_addr <= '0; m_data <= '0;
      any_write <= 1'b0; last_buf <= 1'b0;
    end else begin
      if (us_tick) m_now <= m_now + 1'b1;
      m_en <= wr_valid && exp_ready(wr_addr, m_now, m_last);
      if (wr_valid && exp_ready(wr_addr, m_now, m_last)) begin
        m_last    <= m_now;
        m_addr    <= wr_addr;
        m_data    <= wr_data;
        any_write <= 1'b1;
        last_buf  <= (wr_addr == AW'(BUF));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Tick generator: one-cycle pulse every TICK_DIV cycles.
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
      us_tick = (div == 0) && !rst;
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 200000 && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n_cyc, CYCLES);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic logic [AW-1:0] pick_addr(input bit first);
    int r;
    if (first) return AW'(4);
    r = int'($urandom % 100);
    if (r < 30) return AW'(BUF);
    return AW'(($urandom % 64) * 4);
  endfunction

  initial begin
    int seed;
    string tag;
    logic [CNT_W-1:0] el;
    seed = int'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(per_wr_en == 1'b0, "R1", "per_wr_en after reset", DW'(per_wr_en), 0);
    rst = 1'b0;
    wr_valid = 1'b1;
    wr_addr  = pick_addr(1'b1);
    wr_data  = $urandom;
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      // R5: issue path
      chk(per_wr_en == m_en, "R5", "per_wr_en", DW'(per_wr_en), DW'(m_en));
      if (m_en) begin
        chk(per_wr_addr == m_addr, "R5", "per_wr_addr", DW'(per_wr_addr), DW'(m_addr));
        chk(per_wr_data == m_data, "R5", "per_wr_data", per_wr_data, m_data);
      end
      // R6: read pass-through, also while writes stall
      rd_en       = ($urandom % 2) == 0;
      rd_addr     = AW'($urandom);
      per_rd_data = $urandom;
      #1;
      chk(per_rd_en == rd_en && per_rd_addr == rd_addr, "R6", "read request",
          DW'({per_rd_en, per_rd_addr}), DW'({rd_en, rd_addr}));
      chk(rd_data == per_rd_data, "R6", "read data", rd_data, per_rd_data);
      if (wr_valid) begin
        el = m_now - m_last;
        if (wr_addr == AW'(BUF))            tag = "R3";
        else if (!any_write)                tag = "R1";
        else if (last_buf)                  tag = "R4";
        else if (el == CNT_W'(GAP))         tag = "R8";
        else if (m_now < m_last)            tag = "R7";
        else                                tag = "R2";
        chk(wr_ready == exp_ready(wr_addr, m_now, m_last), tag, "wr_ready",
            DW'(wr_ready), DW'(exp_ready(wr_addr, m_now, m_last)));
      end
      // Next host stimulus: hold a stalled write, else pick a new one.
      if (!(wr_valid && !exp_ready(wr_addr, m_now, m_last))) begin
        if (($urandom % 100) < 20) begin
          wr_valid = 1'b0;
        end else begin
          wr_valid = 1'b1;
          wr_addr  = pick_addr(1'b0);
          wr_data  = $urandom;
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule